// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block holds the pending interrupt causes of a serial port, gates them with a software-controlled enable mask, and drives six interrupt lines: one line that is high whenever any enabled cause is pending, and five lines that each cover a fixed group of causes (receive, transmit, receive timeout, modem lines, line errors). The surrounding peripheral feeds it one-cycle event pulses from its FIFOs, timeout counter, modem-line sampler and receive error detectors; the register decoder feeds it writes to the enable mask and to the clear-on-one acknowledge register, and reads back the pending and the enabled-pending vectors.

Pending bits are sticky until software acknowledges them. An event arriving in the same cycle as an acknowledge of the same cause wins, so no cause is lost. The interrupt lines are registered and are computed from the values the pending and mask registers take at the same clock edge. A mask write or an event is therefore visible on the lines in the very cycle it is visible in the registers.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The status vector has 11 bits with fixed meaning: bit 0 ring indicator, bit 1 CTS, bit 2 DCD, bit 3 DSR, bit 4 receive, bit 5 transmit, bit 6 receive timeout, bit 7 framing error, bit 8 parity error, bit 9 break error, bit 10 overrun error. A 1 on bit i of `evt_set` at a rising edge sets bit i of `raw_stat` after that edge.
- R2: `masked_stat` equals `raw_stat` ANDed bit by bit with the enable mask.
- R3: `irq_any` is high exactly when any bit 0 to 10 of `masked_stat` is set.
- R4: `irq_rx`, `irq_tx` and `irq_rto` follow bits 4, 5 and 6 of `masked_stat` respectively.
- R5: `irq_modem` is high exactly when any of bits 0 to 3 of `masked_stat` is set.
- R6: `irq_err` is high exactly when any of bits 7 to 10 of `masked_stat` is set.
- R7: A cycle with `clr_we` high clears every `raw_stat` bit that is 1 in `clr_wdata`; bits written as 0 keep their value.
- R8: A cycle with `mask_we` high replaces the whole mask with `mask_wdata`; `masked_stat` and all six lines reflect the new mask right after that same edge.
- R9: When `evt_set` and an acknowledge hit the same bit in one cycle, the bit ends up set.
- R10: After synchronous reset the mask, `raw_stat`, `masked_stat` and all six lines are zero.
- R11: With no event and no acknowledge, `raw_stat` keeps its value; a mask write does not alter `raw_stat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 11 | One-cycle event pulses, one per cause |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 11 | New enable mask |
| clr_we | input | 1 | Write strobe for the acknowledge register |
| clr_wdata | input | 11 | Pending bits to clear (1 = clear) |
| raw_stat | output | 11 | Pending causes before masking |
| masked_stat | output | 11 | Pending causes after masking |
| irq_any | output | 1 | Any enabled cause pending |
| irq_rx | output | 1 | Receive cause enabled and pending |
| irq_tx | output | 1 | Transmit cause enabled and pending |
| irq_rto | output | 1 | Receive-timeout cause enabled and pending |
| irq_modem | output | 1 | Any enabled modem-line cause pending |
| irq_err | output | 1 | Any enabled line-error cause pending |

## Verification
On every cycle the assertions check that each line equals its group reduction of the enabled-pending vector, that an event always leaves its bit set, that an acknowledge without a competing event leaves its bits clear, that an idle cycle keeps the pending vector, and that a mask write loads exactly the written value. The bench shows what a property cannot pin down on its own: that every one of the 2048 pending patterns maps onto the right group lines under a full mask, that every one of the 2048 masks gates a full pending vector correctly in the same cycle it is written, and that acknowledging single bits leaves all other bits untouched.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STAT_W    = 11;
  localparam int NUM_LINES = 6;

  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RTO = 6;

  localparam logic [STAT_W-1:0] GRP_ALL   = 11'h7FF;
  localparam logic [STAT_W-1:0] GRP_MODEM = 11'h00F;
  localparam logic [STAT_W-1:0] GRP_ERR   = 11'h780;

  typedef enum int {
    LN_ANY   = 0,
    LN_RX    = 1,
    LN_TX    = 2,
    LN_RTO   = 3,
    LN_MODEM = 4,
    LN_ERR   = 5
  } line_e;

  function automatic logic [STAT_W-1:0] line_sel(input int ln);
    logic [STAT_W-1:0] s;
    s = '0;
    case (ln)
      LN_ANY:   s = GRP_ALL;
      LN_RX:    s[B_RX] = 1'b1;
      LN_TX:    s[B_TX] = 1'b1;
      LN_RTO:   s[B_RTO] = 1'b1;
      LN_MODEM: s = GRP_MODEM;
      LN_ERR:   s = GRP_ERR;
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
  parameter int W = uart_irq_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] pend_next
);
  logic [W-1:0] clr_eff;

  always_comb begin
    clr_eff   = clr_en ? clr_bits : '0;
    pend_next = (pend_q & ~clr_eff) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_next;
  end

  // R1 R9
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  // R7
  clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((pend_q & $past(clr_bits & ~evt)) == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && evt == '0) |=> $stable(pend_q));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int W = uart_irq_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_next
);
  always_comb mask_next = we ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_next;
  end

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (mask_q == $past(wdata)));

  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines #(
  parameter int W = uart_irq_pkg::STAT_W,
  parameter int N = uart_irq_pkg::NUM_LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gated_next,
  output logic [N-1:0] line_q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam logic [W-1:0] SEL = uart_irq_pkg::line_sel(i);
    always_ff @(posedge clk) begin
      if (rst) line_q[i] <= 1'b0;
      else     line_q[i] <= |(gated_next & SEL);
    end
  end

  // R10
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (line_q == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int W = uart_irq_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         clr_we,
  input  logic [W-1:0] clr_wdata,
  output logic [W-1:0] raw_stat,
  output logic [W-1:0] masked_stat,
  output logic         irq_any,
  output logic         irq_rx,
  output logic         irq_tx,
  output logic         irq_rto,
  output logic         irq_modem,
  output logic         irq_err
);
  import uart_irq_pkg::*;

  logic [W-1:0]         pend_q, pend_next;
  logic [W-1:0]         mask_q, mask_next;
  logic [W-1:0]         gated_next;
  logic [NUM_LINES-1:0] lines;

  uart_irq_pend #(.W(W)) u_pend (
    .clk(clk), .rst(rst), .evt(evt_set), .clr_en(clr_we),
    .clr_bits(clr_wdata), .pend_q(pend_q), .pend_next(pend_next)
  );

  uart_irq_mask #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .wdata(mask_wdata),
    .mask_q(mask_q), .mask_next(mask_next)
  );

  always_comb gated_next = pend_next & mask_next;

  uart_irq_lines #(.W(W), .N(NUM_LINES)) u_lines (
    .clk(clk), .rst(rst), .gated_next(gated_next), .line_q(lines)
  );

  always_comb begin
    raw_stat    = pend_q;
    masked_stat = pend_q & mask_q;
    irq_any     = lines[LN_ANY];
    irq_rx      = lines[LN_RX];
    irq_tx      = lines[LN_TX];
    irq_rto     = lines[LN_RTO];
    irq_modem   = lines[LN_MODEM];
    irq_err     = lines[LN_ERR];
  end

  // R3
  any_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any == |(pend_q & mask_q));
  // R4
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    {irq_rto, irq_tx, irq_rx} == (pend_q[B_RTO:B_RX] & mask_q[B_RTO:B_RX]));
  // R5
  modem_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_modem == |(pend_q[3:0] & mask_q[3:0]));
  // R6
  err_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_err == |(pend_q[10:7] & mask_q[10:7]));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] evt_set = '0, mask_wdata = '0, clr_wdata = '0;
  logic mask_we = 1'b0, clr_we = 1'b0;
  logic [W-1:0] raw_stat, masked_stat;
  logic irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

  int total = 0;
  int bad = 0;
  logic [W-1:0] m_raw = '0, m_mask = '0;

  always #5 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst(rst), .evt_set(evt_set), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .irq_any(irq_any),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rto(irq_rto),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string ctx);
    logic [W-1:0] g;
    g = m_raw & m_mask;
    chk({ctx, " R1 raw"}, raw_stat, m_raw);
    chk({ctx, " R2 masked"}, masked_stat, g);
    chk({ctx, " R3 any"}, W'(irq_any), W'(|g));
    chk({ctx, " R4 rx"}, W'(irq_rx), W'(g[4]));
    chk({ctx, " R4 tx"}, W'(irq_tx), W'(g[5]));
    chk({ctx, " R4 rto"}, W'(irq_rto), W'(g[6]));
    chk({ctx, " R5 modem"}, W'(irq_modem), W'(|g[3:0]));
    chk({ctx, " R6 err"}, W'(irq_err), W'(|g[10:7]));
  endtask

  // drive after a falling edge, let one rising edge capture, return at the next falling edge
  task automatic step(input logic [W-1:0] ev, input logic mw, input logic [W-1:0] md,
                      input logic cw, input logic [W-1:0] cd);
    evt_set = ev; mask_we = mw; mask_wdata = md; clr_we = cw; clr_wdata = cd;
    m_raw  = (m_raw & ~(cw ? cd : '0)) | ev;
    m_mask = mw ? md : m_mask;
    @(negedge clk);
    evt_set = '0; mask_we = 1'b0; mask_wdata = '0; clr_we = 1'b0; clr_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset with inputs active must still give zeros
    evt_set = '1; mask_we = 1'b1; mask_wdata = '1;
    repeat (3) @(negedge clk);
    evt_set = '0; mask_we = 1'b0; mask_wdata = '0;
    rst = 1'b0;
    @(negedge clk);
    check_all("R10 reset");

    // R1 R9 R7: full mask, every pattern set while acknowledging everything
    step('0, 1'b1, '1, 1'b0, '0);
    for (int v = 0; v < 2048; v++) begin
      step(W'(v), 1'b0, '0, 1'b1, '1);
      check_all("R9 set-vs-clear sweep");
    end

    // R8 R11: full pending vector, every mask, checked in the write's own cycle
    step('1, 1'b0, '0, 1'b0, '0);
    for (int m = 0; m < 2048; m++) begin
      step('0, 1'b1, W'(m), 1'b0, '0);
      check_all("R8 mask sweep");
      chk("R11 raw after mask write", raw_stat, 11'h7FF);
    end

    // R7: clear one bit at a time, others untouched
    step('0, 1'b1, '1, 1'b0, '0);
    for (int k = 0; k < W; k++) begin
      step('0, 1'b0, '0, 1'b1, W'(1) << k);
      check_all("R7 single clear");
    end

    // R7: clear write with zero data keeps state
    step(11'h555, 1'b0, '0, 1'b0, '0);
    step('0, 1'b0, '0, 1'b1, '0);
    check_all("R7 zero clear");
    chk("R7 zero clear keeps", raw_stat, 11'h555);

    // R11: idle cycles hold
    for (int i = 0; i < 4; i++) begin
      step('0, 1'b0, '0, 1'b0, '0);
      check_all("R11 idle hold");
    end

    // R9: partial overlap of event and acknowledge
    step(11'h0F0, 1'b0, '0, 1'b1, 11'h3FC);
    check_all("R9 overlap");

    // R10: reset again after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_raw = '0; m_mask = '0;
    check_all("R10 re-reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule